// File: doc/BRIEF.md
# Ingress Watermark Backpressure Generator

This block decides when a packet ingress port must ask its sender to pause. Two conditions can start a pause. The first is the fill level of the shared ingress buffer. It is compared with a programmable watermark, given in sixteenths of the buffer, where one sixteenth is 128 bytes. The second is the free-segment count of any identifier that is both active and enabled in its map. If such a count drops to that identifier's own threshold, a pause is requested as well. A global enable decides whether backpressure is driven at all. With the enable clear, the sender is never paused, and data may be lost.

A small state machine holds the decision. It has three states:
- `BP_OFF`: backpressure is disabled.
- `BP_OPEN`: enabled, and no pause is requested.
- `BP_HOLD`: enabled, and a pause is requested.

Its transitions are:
- `go_off`: any state moves to `BP_OFF` when the enable is clear.
- `go_open`: `BP_OFF` or `BP_HOLD` moves to `BP_OPEN` when the enable is set and neither trigger is present.
- `go_hold`: `BP_OFF` or `BP_OPEN` moves to `BP_HOLD` when the enable is set and either trigger is present.
- Every other case keeps the current state.

The backpressure output is decoded from the state register, so it follows its inputs by one clock.

Separately, the block flags an overflow. This happens when a fragment arrives for an identifier whose free-segment count is zero. The flag is a one-cycle event that carries the identifier.

Top module: `ingress_bp_gen`

## Requirements
- R1: After reset, `bp_out` and `ovf_evt` are 0.
- R2: While `cfg_bp_en` is 0, `bp_out` is 0 from the next cycle on. This holds whatever the fill level and free-segment counts are, and it also drops a pause that is already being held.
- R3: With `cfg_bp_en` at 1, `bp_out` is 1 in the cycle after `fill_bytes` reaches or exceeds `cfg_wm`×128. For example, with `cfg_wm`=8 a fill of 1023 gives 0 and a fill of 1024 gives 1.
- R4: `cfg_wm`=16 asserts backpressure only at a completely full buffer (2048 bytes). Any `cfg_wm` value above 16 behaves as 16.
- R5: With `cfg_bp_en` at 1, `bp_out` is 1 in the cycle after an identifier i meets all of these conditions:
  - `id_active[i]`=1 and `id_map_en[i]`=1;
  - its free-segment field (bits i×SEG_W upward in `seg_free`) is less than or equal to its threshold field in `seg_thr`.
- R6: An identifier whose `id_map_en` bit is 0, or whose `id_active` bit is 0, has no effect on `bp_out`.
- R7: `bp_out` returns to 0 in the cycle after both the fill trigger and every identifier trigger have cleared.
- R8: When `frag_vld` is 1 and the free-segment field of `frag_id` is 0, then in the next cycle `ovf_evt` is 1 and `ovf_id` equals that identifier. In every other case `ovf_evt` is 0 in the next cycle.
- R9: A change on any input is not visible on `bp_out` before the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_bp_en | input | 1 | Global backpressure enable |
| cfg_wm | input | WM_W (5) | Watermark in sixteenths of the buffer |
| fill_bytes | input | FILL_W (12) | Current buffer fill in bytes |
| id_active | input | NUM_ID (8) | Identifier is active |
| id_map_en | input | NUM_ID (8) | Identifier map entry is enabled |
| seg_free | input | NUM_ID×SEG_W (48) | Free-segment count per identifier, packed |
| seg_thr | input | NUM_ID×SEG_W (48) | Free-segment threshold per identifier, packed |
| frag_vld | input | 1 | A fragment is arriving |
| frag_id | input | ID_W (3) | Identifier of the arriving fragment |
| bp_out | output | 1 | Backpressure request |
| ovf_evt | output | 1 | Overflow event pulse |
| ovf_id | output | ID_W (3) | Identifier of the overflow |

## Verification
Every result of this block is due exactly one rising edge after the stimulus that causes it. This applies to the backpressure level, its release and the overflow pulse.

The bench changes inputs on the falling edge and reads the outputs on the next falling edge, which lands half a period after the one register has loaded. For R9, it also reads `bp_out` 1 ns after driving a trigger, before any rising edge, and expects the old value. Threshold tests place the input one step below the boundary and then exactly at it.

// File: rtl/ibp_pkg.sv
package ibp_pkg;
    typedef enum logic [1:0] {
        BP_OFF  = 2'd0,
        BP_OPEN = 2'd1,
        BP_HOLD = 2'd2
    } bp_state_t;
endpackage

// File: rtl/ibp_level_cmp.sv
module ibp_level_cmp #(
    parameter int UNIT_BYTES = 128,
    parameter int STEPS      = 16,
    parameter int WM_W       = 5,
    parameter int FILL_W     = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WM_W-1:0]   wm,
    input  logic [FILL_W-1:0] fill,
    output logic              hit
);
    localparam logic [WM_W-1:0]   WM_MAX  = WM_W'(STEPS);
    localparam logic [FILL_W-1:0] UNIT_V  = FILL_W'(UNIT_BYTES);
    localparam logic [FILL_W-1:0] FULL_V  = FILL_W'(UNIT_BYTES * STEPS);

    logic [WM_W-1:0]   wm_eff;
    logic [FILL_W-1:0] thr_bytes;

    always_comb begin
        wm_eff    = (wm > WM_MAX) ? WM_MAX : wm;
        thr_bytes = FILL_W'(wm_eff) * UNIT_V;
        hit       = (fill >= thr_bytes);
    end

    // R4
    top_wm_full_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wm >= WM_MAX && fill < FULL_V) |-> !hit);
endmodule

// File: rtl/ibp_seg_scan.sv
module ibp_seg_scan #(
    parameter int NUM_ID = 8,
    parameter int SEG_W  = 6
) (
    input  logic [NUM_ID-1:0]       active,
    input  logic [NUM_ID-1:0]       map_en,
    input  logic [NUM_ID*SEG_W-1:0] free_cnt,
    input  logic [NUM_ID*SEG_W-1:0] thr,
    output logic                    hit
);
    logic [NUM_ID-1:0] short_q;

    for (genvar g = 0; g < NUM_ID; g++) begin : g_id
        assign short_q[g] = active[g] & map_en[g] &
                            (free_cnt[g*SEG_W +: SEG_W] <= thr[g*SEG_W +: SEG_W]);
    end

    assign hit = |short_q;
endmodule

// File: rtl/ibp_ovf_det.sv
module ibp_ovf_det #(
    parameter int NUM_ID = 8,
    parameter int SEG_W  = 6,
    parameter int ID_W   = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    frag_vld,
    input  logic [ID_W-1:0]         frag_id,
    input  logic [NUM_ID*SEG_W-1:0] free_cnt,
    output logic                    ovf_evt,
    output logic [ID_W-1:0]         ovf_id
);
    logic [SEG_W-1:0] free_sel;

    always_comb begin
        free_sel = '0;
        for (int i = 0; i < NUM_ID; i++) begin
            if (frag_id == ID_W'(i)) free_sel = free_cnt[i*SEG_W +: SEG_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovf_evt <= 1'b0;
            ovf_id  <= '0;
        end else begin
            ovf_evt <= frag_vld && (free_sel == '0);
            ovf_id  <= frag_id;
        end
    end

    // R8
    ovf_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frag_vld |=> !ovf_evt);
    // R8
    ovf_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frag_vld |=> (ovf_id == $past(frag_id)));
endmodule

// File: rtl/ingress_bp_gen.sv
module ingress_bp_gen
    import ibp_pkg::*;
#(
    parameter int NUM_ID     = 8,
    parameter int SEG_W      = 6,
    parameter int UNIT_BYTES = 128,
    parameter int STEPS      = 16,
    parameter int WM_W       = $clog2(STEPS + 1),
    parameter int FILL_W     = $clog2(UNIT_BYTES * STEPS + 1),
    parameter int ID_W       = (NUM_ID > 1) ? $clog2(NUM_ID) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_bp_en,
    input  logic [WM_W-1:0]         cfg_wm,
    input  logic [FILL_W-1:0]       fill_bytes,
    input  logic [NUM_ID-1:0]       id_active,
    input  logic [NUM_ID-1:0]       id_map_en,
    input  logic [NUM_ID*SEG_W-1:0] seg_free,
    input  logic [NUM_ID*SEG_W-1:0] seg_thr,
    input  logic                    frag_vld,
    input  logic [ID_W-1:0]         frag_id,
    output logic                    bp_out,
    output logic                    ovf_evt,
    output logic [ID_W-1:0]         ovf_id
);
    logic      lvl_hit;
    logic      seg_hit;
    logic      trig;
    bp_state_t state_q;
    bp_state_t state_d;

    ibp_level_cmp #(
        .UNIT_BYTES(UNIT_BYTES), .STEPS(STEPS), .WM_W(WM_W), .FILL_W(FILL_W)
    ) u_level (
        .clk(clk), .rst_n(rst_n), .wm(cfg_wm), .fill(fill_bytes), .hit(lvl_hit)
    );

    ibp_seg_scan #(.NUM_ID(NUM_ID), .SEG_W(SEG_W)) u_scan (
        .active(id_active), .map_en(id_map_en),
        .free_cnt(seg_free), .thr(seg_thr), .hit(seg_hit)
    );

    ibp_ovf_det #(.NUM_ID(NUM_ID), .SEG_W(SEG_W), .ID_W(ID_W)) u_ovf (
        .clk(clk), .rst_n(rst_n), .frag_vld(frag_vld), .frag_id(frag_id),
        .free_cnt(seg_free), .ovf_evt(ovf_evt), .ovf_id(ovf_id)
    );

    assign trig = lvl_hit | seg_hit;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BP_OFF: begin
                if (cfg_bp_en) state_d = trig ? BP_HOLD : BP_OPEN;
            end
            BP_OPEN: begin
                if (!cfg_bp_en) state_d = BP_OFF;
                else if (trig)  state_d = BP_HOLD;
            end
            BP_HOLD: begin
                if (!cfg_bp_en) state_d = BP_OFF;
                else if (!trig) state_d = BP_OPEN;
            end
            default: state_d = BP_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BP_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        bp_out = (state_q == BP_HOLD);
    end

    // R2
    bp_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_bp_en |=> !bp_out);
    // R3
    bp_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_bp_en && lvl_hit) |=> bp_out);
    // R5
    bp_seg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_bp_en && seg_hit) |=> bp_out);
    // R7
    bp_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!lvl_hit && !seg_hit) |=> !bp_out);
endmodule

// File: tb/test_ingress_bp_gen.sv
module test_ingress_bp_gen;
    localparam int NUM_ID = 8;
    localparam int SEG_W  = 6;
    localparam int WM_W   = 5;
    localparam int FILL_W = 12;
    localparam int ID_W   = 3;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    cfg_bp_en = 1'b0;
    logic [WM_W-1:0]         cfg_wm = 5'd16;
    logic [FILL_W-1:0]       fill_bytes = '0;
    logic [NUM_ID-1:0]       id_active = '0;
    logic [NUM_ID-1:0]       id_map_en = '0;
    logic [NUM_ID*SEG_W-1:0] seg_free = '0;
    logic [NUM_ID*SEG_W-1:0] seg_thr = '0;
    logic                    frag_vld = 1'b0;
    logic [ID_W-1:0]         frag_id = '0;
    logic                    bp_out;
    logic                    ovf_evt;
    logic [ID_W-1:0]         ovf_id;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    ingress_bp_gen i_ingress_bp_gen (
        .clk(clk), .rst_n(rst_n), .cfg_bp_en(cfg_bp_en), .cfg_wm(cfg_wm),
        .fill_bytes(fill_bytes), .id_active(id_active), .id_map_en(id_map_en),
        .seg_free(seg_free), .seg_thr(seg_thr), .frag_vld(frag_vld),
        .frag_id(frag_id), .bp_out(bp_out), .ovf_evt(ovf_evt), .ovf_id(ovf_id)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_id(input int i, input int free_v, input int thr_v);
        seg_free[i*SEG_W +: SEG_W] = SEG_W'(free_v);
        seg_thr[i*SEG_W +: SEG_W]  = SEG_W'(thr_v);
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 bp after reset", int'(bp_out), 0);
        check("R1 ovf after reset", int'(ovf_evt), 0);
    endtask

    task automatic t_disabled();
        cfg_bp_en = 1'b0; cfg_wm = 5'd8; fill_bytes = 12'd2048;
        set_id(0, 0, 2); id_active[0] = 1'b1; id_map_en[0] = 1'b1;
        step(); check("R2 disabled full buffer", int'(bp_out), 0);
        step(); check("R2 disabled still", int'(bp_out), 0);
        id_active[0] = 1'b0; id_map_en[0] = 1'b0; set_id(0, 10, 0);
        fill_bytes = '0; cfg_bp_en = 1'b1;
        step(); check("R7 enabled no trigger", int'(bp_out), 0);
    endtask

    task automatic t_level();
        cfg_wm = 5'd8; fill_bytes = 12'd1023;
        step(); check("R3 wm8 fill1023", int'(bp_out), 0);
        fill_bytes = 12'd1024;
        #1 check("R9 no change before edge", int'(bp_out), 0);
        step(); check("R3 wm8 fill1024", int'(bp_out), 1);
        fill_bytes = 12'd1023;
        step(); check("R7 release below wm", int'(bp_out), 0);
    endtask

    task automatic t_full();
        cfg_wm = 5'd16; fill_bytes = 12'd2047;
        step(); check("R4 wm16 fill2047", int'(bp_out), 0);
        fill_bytes = 12'd2048;
        step(); check("R4 wm16 full", int'(bp_out), 1);
        cfg_wm = 5'd31; fill_bytes = 12'd2047;
        step(); check("R4 wm31 fill2047", int'(bp_out), 0);
        fill_bytes = 12'd2048;
        step(); check("R4 wm31 full", int'(bp_out), 1);
        cfg_bp_en = 1'b0;
        step(); check("R2 disable drops hold", int'(bp_out), 0);
        cfg_bp_en = 1'b1; fill_bytes = '0; cfg_wm = 5'd16;
        step(); check("R7 idle after reenable", int'(bp_out), 0);
    endtask

    task automatic t_seg();
        id_active[3] = 1'b1; id_map_en[3] = 1'b1; set_id(3, 5, 4);
        step(); check("R5 free above thr", int'(bp_out), 0);
        set_id(3, 4, 4);
        #1 check("R9 seg no change before edge", int'(bp_out), 0);
        step(); check("R5 free at thr", int'(bp_out), 1);
        set_id(3, 5, 4);
        step(); check("R7 seg release", int'(bp_out), 0);
        id_active[3] = 1'b0; id_map_en[3] = 1'b0;
    endtask

    task automatic t_ignore();
        set_id(5, 0, 4); id_active[5] = 1'b1; id_map_en[5] = 1'b0;
        step(); check("R6 map disabled ignored", int'(bp_out), 0);
        id_active[5] = 1'b0; id_map_en[5] = 1'b1;
        step(); check("R6 inactive ignored", int'(bp_out), 0);
        id_active[5] = 1'b1;
        step(); check("R5 both set takes effect", int'(bp_out), 1);
        id_active[5] = 1'b0; id_map_en[5] = 1'b0; set_id(5, 10, 0);
        step(); check("R7 release after ignore", int'(bp_out), 0);
    endtask

    task automatic t_ovf();
        set_id(2, 0, 0); frag_id = 3'd2; frag_vld = 1'b1;
        step(); check("R8 ovf pulse", int'(ovf_evt), 1);
        check("R8 ovf id", int'(ovf_id), 2);
        frag_vld = 1'b0;
        step(); check("R8 ovf single cycle", int'(ovf_evt), 0);
        frag_id = 3'd3; frag_vld = 1'b1;
        step(); check("R8 no ovf with free space", int'(ovf_evt), 0);
        frag_vld = 1'b0; set_id(2, 10, 0);
        step();
    endtask

    initial begin
        for (int i = 0; i < NUM_ID; i++) set_id(i, 10, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step();
        t_reset();
        t_disabled();
        t_level();
        t_full();
        t_seg();
        t_ignore();
        t_ovf();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule